// File: doc/BRIEF.md
# 2D Transfer Mode Sequencer

This block is the control core of a 2D graphics DMA engine. A single-cycle start pulse launches a transfer over a rectangle of ARGB8888 pixels, whose size is set by a pixel count per line and a line count. For every pixel the sequencer runs only the stages that the selected mode needs. Those stages are a foreground word read, a background word read, an alpha blend and an output word write. Each word access goes out on a valid/ready request port, and read data comes back on a separate response strobe.

Mode 0 fills the target rectangle with a fixed colour and reads nothing. Mode 1 copies foreground words without change. Mode 2 copies foreground words and converts each one from packed RGB888 to opaque ARGB8888. Mode 3 reads both sources and blends them using the foreground alpha. The three addresses count in bytes and advance by 4 for each pixel. At the end of each line, every address also skips its own line offset, so the engine can address a sub-rectangle of a larger frame. When the last write is accepted, a one-cycle done pulse follows.

Top module: `gfx_xfer_seq`

## Requirements
- R1: Mode 0 (`mode`=2'd0) issues no read requests and writes `fill_color` to every pixel of the rectangle.
- R2: Mode 1 writes each foreground word unchanged.
- R3: Mode 2 writes `{8'hFF, fg[23:0]}`: the low 24 bits of the foreground word are kept and the top byte (alpha) is forced to 255.
- R4: Mode 3 writes `{8'hFF, r, g, b}`. Each channel equals (f·a + b·(255−a)) / 255 with the result truncated. Here a = fg[31:24], and the channels sit at bits [23:16], [15:8] and [7:0].
- R5: Within one pixel the requests run in the order foreground read, background read (mode 3 only), then write. A new request is never issued until the previous read's response has arrived.
- R6: Pixels are visited line by line in raster order. The foreground, background and output addresses each start at their base and step by 4 per pixel. After the last pixel of a line, each address also adds 4 × its own line offset (the offsets count in pixels).
- R7: Address arithmetic wraps modulo 2^32.
- R8: A start with a zero pixel count or a zero line count raises `done` in the next cycle and issues no requests.
- R9: `done` is high for exactly one cycle, in the cycle after the last write is accepted, and `busy` is low in that cycle.
- R10: A start pulse that arrives while `busy` is high is ignored.
- R11: A request that is not accepted holds `req_valid` high, with its address, direction and write data unchanged, until `req_ready` accepts it.
- R12: The mode, bases, counts, offsets and fill colour are captured at start. Later changes on those inputs do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer launch pulse |
| mode | input | 2 | 0 fill, 1 copy, 2 copy with RGB888 to ARGB8888, 3 blend |
| fg_base | input | 32 | Foreground start byte address |
| bg_base | input | 32 | Background start byte address |
| out_base | input | 32 | Output start byte address |
| line_px | input | CNT_W | Pixels per line |
| line_num | input | CNT_W | Number of lines |
| fg_skip | input | CNT_W | Foreground line offset in pixels |
| bg_skip | input | CNT_W | Background line offset in pixels |
| out_skip | input | CNT_W | Output line offset in pixels |
| fill_color | input | 32 | Colour written in mode 0 |
| req_valid | output | 1 | Memory request valid |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_addr | output | 32 | Request byte address |
| req_wdata | output | 32 | Write data |
| req_ready | input | 1 | Request accepted when high together with `req_valid` |
| rsp_valid | input | 1 | Read data strobe |
| rsp_data | input | 32 | Read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory side returns exactly one `rsp_valid` for each accepted read, always after the read has been accepted, and never raises it while no read is outstanding. The bench's memory model holds to this. It keeps a single pending response with a random latency of one to three cycles, drives `req_ready` at random, and computes read data as a hash of the address. As a result, every write value the bench expects follows from the address sequence alone.

// File: rtl/gfx_xfer_seq.sv
module gfx_xfer_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [31:0]      fg_base,
  input  logic [31:0]      bg_base,
  input  logic [31:0]      out_base,
  input  logic [CNT_W-1:0] line_px,
  input  logic [CNT_W-1:0] line_num,
  input  logic [CNT_W-1:0] fg_skip,
  input  logic [CNT_W-1:0] bg_skip,
  input  logic [CNT_W-1:0] out_skip,
  input  logic [31:0]      fill_color,
  output logic             req_valid,
  output logic             req_write,
  output logic [31:0]      req_addr,
  output logic [31:0]      req_wdata,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [31:0]      rsp_data,
  output logic             busy,
  output logic             done
);
  localparam int PAD = 32 - CNT_W - 2;
  localparam logic [1:0] M_FILL = 2'd0, M_COPY = 2'd1, M_BLEND = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FG_REQ, S_FG_WAIT, S_BG_REQ, S_BG_WAIT, S_MIX, S_WR} st_t;

  st_t              st;
  logic [1:0]       mode_q;
  logic [31:0]      fg_a, bg_a, out_a, fill_q, fg_q, bg_q, pix_q;
  logic [CNT_W-1:0] npx_q, nln_q, px, ln, fg_off, bg_off, out_off;

  function automatic logic [7:0] mix(input logic [7:0] f, input logic [7:0] b, input logic [7:0] a);
    logic [15:0] s;
    s = 16'(f) * 16'(a) + 16'(b) * 16'(8'd255 - a);
    return 8'(s / 16'd255);
  endfunction

  function automatic logic [31:0] line_step(input logic [CNT_W-1:0] off);
    return 32'd4 + {{PAD{1'b0}}, off, 2'b00};
  endfunction

  wire wr_fire  = (st == S_WR) && req_ready;
  wire last_px  = (px == npx_q - 1'b1);
  wire last_ln  = (ln == nln_q - 1'b1);

  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_FG_REQ) || (st == S_BG_REQ) || (st == S_WR);
  assign req_write = (st == S_WR);
  assign req_addr  = (st == S_FG_REQ) ? fg_a : (st == S_BG_REQ) ? bg_a : out_a;
  assign req_wdata = (mode_q == M_FILL) ? fill_q : pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= '0; done <= 1'b0;
      fg_a <= '0; bg_a <= '0; out_a <= '0;
      fill_q <= '0; fg_q <= '0; bg_q <= '0; pix_q <= '0;
      npx_q <= '0; nln_q <= '0; px <= '0; ln <= '0;
      fg_off <= '0; bg_off <= '0; out_off <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (line_px == '0 || line_num == '0) done <= 1'b1;
          else begin
            mode_q <= mode; fg_a <= fg_base; bg_a <= bg_base; out_a <= out_base;
            npx_q <= line_px; nln_q <= line_num; px <= '0; ln <= '0;
            fg_off <= fg_skip; bg_off <= bg_skip; out_off <= out_skip;
            fill_q <= fill_color;
            st <= (mode == M_FILL) ? S_WR : S_FG_REQ;
          end
        end
        S_FG_REQ: if (req_ready) st <= S_FG_WAIT;
        S_FG_WAIT: if (rsp_valid) begin
          fg_q <= rsp_data;
          if (mode_q == M_BLEND) st <= S_BG_REQ;
          else begin
            pix_q <= (mode_q == M_COPY) ? rsp_data : {8'hFF, rsp_data[23:0]};
            st <= S_WR;
          end
        end
        S_BG_REQ: if (req_ready) st <= S_BG_WAIT;
        S_BG_WAIT: if (rsp_valid) begin
          bg_q <= rsp_data;
          st <= S_MIX;
        end
        S_MIX: begin
          pix_q <= {8'hFF, mix(fg_q[23:16], bg_q[23:16], fg_q[31:24]),
                           mix(fg_q[15:8],  bg_q[15:8],  fg_q[31:24]),
                           mix(fg_q[7:0],   bg_q[7:0],   fg_q[31:24])};
          st <= S_WR;
        end
        S_WR: if (wr_fire) begin
          if (last_px) begin
            px <= '0; ln <= ln + 1'b1;
            fg_a <= fg_a + line_step(fg_off);
            bg_a <= bg_a + line_step(bg_off);
            out_a <= out_a + line_step(out_off);
          end else begin
            px <= px + 1'b1;
            fg_a <= fg_a + 32'd4; bg_a <= bg_a + 32'd4; out_a <= out_a + 32'd4;
          end
          if (last_px && last_ln) begin
            st <= S_IDLE; done <= 1'b1;
          end else st <= (mode_q == M_FILL) ? S_WR : S_FG_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfx_xfer_seq_chk.sv
module gfx_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        req_ready,
  input logic [1:0]  mode_q
);
  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_q == 2'd0 |-> !(req_valid && !req_write)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(busy) |-> $past(req_valid && req_write && req_ready)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R8
  AST_BUSY_UNTIL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(req_valid && req_write && req_ready) |=> busy); // R10
endmodule

bind gfx_xfer_seq gfx_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_ready(req_ready), .mode_q(mode_q)
);

// File: tb/gfx_xfer_seq_tb.sv
module gfx_xfer_seq_tb;
  localparam int CW = 16;
  localparam int NMAX = 4096;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [31:0] fg_base = '0, bg_base = '0, out_base = '0, fill_color = '0;
  logic [CW-1:0] line_px = '0, line_num = '0, fg_skip = '0, bg_skip = '0, out_skip = '0;
  logic req_valid, req_write, req_ready = 1'b0, rsp_valid = 1'b0, busy, done;
  logic [31:0] req_addr, req_wdata, rsp_data = '0;

  gfx_xfer_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .fg_base(fg_base), .bg_base(bg_base), .out_base(out_base),
    .line_px(line_px), .line_num(line_num),
    .fg_skip(fg_skip), .bg_skip(bg_skip), .out_skip(out_skip),
    .fill_color(fill_color), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done));

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic        e_wr [NMAX];
  logic [31:0] e_addr [NMAX];
  logic [31:0] e_data [NMAX];
  int n_exp = 0, got = 0, done_cnt = 0;
  bit last_hs = 0, zero_run = 0, mon_on = 0;
  int pend = 0;
  logic [31:0] pend_data = '0;
  logic [1:0] cur_mode = '0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h1234_5677;
  endfunction

  function automatic logic [7:0] bl(input logic [7:0] f, input logic [7:0] b, input logic [7:0] a);
    int s;
    s = int'(f) * int'(a) + int'(b) * (255 - int'(a));
    return 8'(s / 255);
  endfunction

  function automatic string rtag(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [31:0] a, input logic [31:0] d);
    e_wr[n_exp] = w; e_addr[n_exp] = a; e_data[n_exp] = d; n_exp++;
  endtask

  task automatic build(input logic [1:0] m, input logic [31:0] fb, input logic [31:0] bb, input logic [31:0] ob,
                       input int np, input int nl, input int fo, input int bo, input int oo, input logic [31:0] fc);
    logic [31:0] fa, ba, oa, f, b, d;
    fa = fb; ba = bb; oa = ob; n_exp = 0;
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++) begin
        f = memf(fa); b = memf(ba);
        if (m != 2'd0) push(1'b0, fa, '0);
        if (m == 2'd3) push(1'b0, ba, '0);
        case (m)
          2'd0: d = fc;
          2'd1: d = f;
          2'd2: d = {8'hFF, f[23:0]};
          default: d = {8'hFF, bl(f[23:16], b[23:16], f[31:24]), bl(f[15:8], b[15:8], f[31:24]), bl(f[7:0], b[7:0], f[31:24])};
        endcase
        push(1'b1, oa, d);
        fa += 4; ba += 4; oa += 4;
      end
      fa += 32'(fo * 4); ba += 32'(bo * 4); oa += 32'(oo * 4);
    end
  endtask

  initial begin : memory_model
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
      if (mon_on && done) begin
        done_cnt++;
        check(last_hs || zero_run, "R9", "done timing", 32'(done), 32'(last_hs || zero_run));
      end
      last_hs = 0;
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin rsp_valid = 1'b1; rsp_data = pend_data; end
      end
      req_ready = ($urandom % 4) != 0;
      #1;
      if (mon_on && req_valid && req_ready) begin
        if (got >= n_exp) check(0, "R5", "extra request", req_addr, '0);
        else begin
          check(req_write == e_wr[got], "R5", "request kind", 32'(req_write), 32'(e_wr[got]));
          check(req_addr == e_addr[got], "R6", "address", req_addr, e_addr[got]);
          if (req_write) check(req_wdata == e_data[got], rtag(cur_mode), "write data", req_wdata, e_data[got]);
          got++;
          if (got == n_exp) last_hs = 1;
        end
        if (!req_write) begin pend = 1 + ($urandom % 3); pend_data = memf(req_addr); end
      end
    end
  end

  task automatic run(input logic [1:0] m, input logic [31:0] fb, input logic [31:0] bb, input logic [31:0] ob,
                     input int np, input int nl, input int fo, input int bo, input int oo,
                     input logic [31:0] fc, input bit poke);
    int w;
    build(m, fb, bb, ob, np, nl, fo, bo, oo, fc);
    cur_mode = m; got = 0; done_cnt = 0; zero_run = (np == 0 || nl == 0); mon_on = 1;
    @(negedge clk);
    mode = m; fg_base = fb; bg_base = bb; out_base = ob; line_px = CW'(np); line_num = CW'(nl);
    fg_skip = CW'(fo); bg_skip = CW'(bo); out_skip = CW'(oo); fill_color = fc; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (zero_run) begin
      #1;
      check(done === 1'b1, "R8", "done after zero-size start", 32'(done), 32'd1);
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      mode = ~m; fg_base = 32'hDEAD_0000; out_base = 32'hBEEF_0000; line_px = 1; line_num = 1;
      fill_color = ~fc; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    check(got == n_exp, zero_run ? "R8" : "R6", "request count", 32'(got), 32'(n_exp));
    check(done_cnt == 1, "R9", "done pulse count", 32'(done_cnt), 32'd1);
    if (poke) check(!busy, "R10", "no second transfer after ignored start", 32'(busy), 32'd0);
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0 && busy == 1'b0 && done == 1'b0, "R9", "reset state", {req_valid, busy, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(2'd0, 32'h0, 32'h0, 32'h1000, 4, 3, 0, 0, 2, 32'hCAFE_F00D, 0);   // R1 R6
    run(2'd1, 32'h2000, 32'h0, 32'h3000, 5, 2, 3, 0, 1, 32'h0, 0);        // R2
    run(2'd2, 32'h4000, 32'h0, 32'h5000, 3, 3, 1, 0, 0, 32'h0, 0);        // R3
    run(2'd3, 32'h6000, 32'h7000, 32'h8000, 4, 3, 2, 5, 1, 32'h0, 0);     // R4 R5
    run(2'd3, 32'hFFFF_FFF8, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 3, 2, 1, 0, 0, 32'h0, 0); // R7
    run(2'd1, 32'h100, 32'h0, 32'h200, 0, 3, 0, 0, 0, 32'h0, 0);          // R8 zero pixels
    run(2'd3, 32'h100, 32'h0, 32'h200, 3, 0, 0, 0, 0, 32'h0, 0);          // R8 zero lines
    run(2'd1, 32'h9000, 32'h0, 32'hA000, 3, 2, 0, 0, 0, 32'h0, 1);        // R10 R12
    run(2'd0, 32'h0, 32'h0, 32'hB000, 2, 2, 0, 0, 0, 32'h1234_5678, 1);   // R10 R12
    for (int i = 0; i < 12; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      run(m, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
          1 + int'($urandom % 6), 1 + int'($urandom % 4), int'($urandom % 6), int'($urandom % 6),
          int'($urandom % 6), $urandom, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule